// File: doc/BRIEF.md
# Two-Channel DC Offset Removal Filter with Freeze

This block sits after a decimation stage and strips the DC component from a stereo stream of signed 24-bit samples. It runs once per output sample, not at the modulator rate. Each channel keeps its own running estimate of the DC level in a fractional accumulator. The integer part of that estimate is subtracted from every incoming sample, and the result saturates to the signed 24-bit range.

A freeze input stops both estimates from learning while the held values are still subtracted. This supports a system offset calibration. The filter first runs in tracking mode until the estimates settle. Freeze is then asserted, and from that point the learned offset of the whole analogue path ahead of the block is removed from every later sample. Releasing freeze resumes learning from the held value.

An enable input selects bypass when low. In bypass the samples pass through unchanged and the estimates are held.

Top module: `dc_block_filter`

## Requirements
- R1: After the asynchronous reset `rst_ni`, `valid_o` is 0, both outputs are 0 and both estimates are 0, so the first sample is passed through unchanged.
- R2: `valid_o` rises exactly one clock after a clock edge that samples `valid_i` high. When `valid_i` is low, `valid_o` is low and `left_o`/`right_o` keep their previous values.
- R3: For each valid sample in tracking or freeze mode, the output is x − E, where E = floor(A / 2^12) and A is the channel's accumulator value before the sample is applied.
- R4: In tracking mode (`enable_i`=1 and no effective freeze), each valid sample updates A ← A + floor((x·2^12 − A) / 2^12). The two channels update independently.
- R5: The difference x − E saturates to the range −8388608 … 8388607 instead of wrapping.
- R6: While freeze is effective (`freeze_i`=1 after at least one valid sample since reset), neither accumulator changes, and the held estimate is still subtracted.
- R7: Freeze has no effect until the first valid sample after reset. That sample updates the estimate even when `freeze_i` is high.
- R8: When `freeze_i` falls, updating resumes from the held accumulator value with no jump in the output.
- R9: With `enable_i`=0, each valid sample is output unchanged and both accumulators hold their values.
- R10: The synchronous reset `srst_i` clears the accumulators, the first-sample flag, the outputs and `valid_o` at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| srst_i | input | 1 | Synchronous clear, active high |
| valid_i | input | 1 | Input sample strobe |
| enable_i | input | 1 | 1 = filter active, 0 = bypass |
| freeze_i | input | 1 | 1 = hold the offset estimates |
| left_i | input | 24 | Left input sample, two's complement |
| right_i | input | 24 | Right input sample, two's complement |
| valid_o | output | 1 | Output sample strobe |
| left_o | output | 24 | Corrected left sample |
| right_o | output | 24 | Corrected right sample |

## Verification
The filter is exercised with several input patterns, each chosen to separate a different failure:

- **Constant DC levels of opposite sign on the two channels.** These separate a correct per-channel update from shared or swapped state. They also expose rounding errors in the floor of the estimate as it converges.
- **DC with a ripple under a gapped strobe.** This shows whether learning happens only on valid samples and whether outputs hold during gaps.
- **A step in DC while frozen, then release.** This tells a held, still-subtracted estimate apart from a bypass or a reset estimate, and a smooth resume apart from a jump.
- **Full-scale samples of the opposite sign after a large offset has been learned.** These drive the subtraction past both limits and separate saturation from wrap-around.
- **Freeze asserted from reset, bypass, and a mid-stream synchronous clear.** These cover the remaining mode corners.

// File: rtl/dcf_pkg.sv
package dcf_pkg;
  typedef enum logic [1:0] {
    MODE_BYPASS = 2'd0,
    MODE_TRACK  = 2'd1,
    MODE_HOLD   = 2'd2
  } dcf_mode_e;
endpackage

// File: rtl/dcf_sat.sv
module dcf_sat #(
  parameter int IN_W  = 26,
  parameter int OUT_W = 24
) (
  input  logic signed [IN_W-1:0]  din_i,
  output logic signed [OUT_W-1:0] dout_o
);
  localparam int TOP_W = IN_W - OUT_W + 1;

  logic [TOP_W-1:0] top_bits;
  logic             in_range;

  assign top_bits = din_i[IN_W-1:OUT_W-1];
  assign in_range = (&top_bits) | (~|top_bits);

  always_comb begin
    if (in_range)        dout_o = din_i[OUT_W-1:0];
    else if (din_i[IN_W-1]) dout_o = {1'b1, {(OUT_W-1){1'b0}}};
    else                 dout_o = {1'b0, {(OUT_W-1){1'b1}}};
  end
endmodule

// File: rtl/dcf_channel.sv
module dcf_channel
  import dcf_pkg::*;
#(
  parameter int SMP_W   = 24,
  parameter int SHIFT_K = 12
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   srst_i,
  input  logic                   valid_i,
  input  dcf_mode_e              mode_i,
  input  logic [SMP_W-1:0]       smp_i,
  output logic [SMP_W-1:0]       res_o,
  output logic [SMP_W+SHIFT_K:0] acc_o
);
  localparam int ACC_W = SMP_W + SHIFT_K + 1; // one guard bit above the sample range
  localparam int EST_W = SMP_W + 1;
  localparam int SUB_W = SMP_W + 2;

  logic signed [ACC_W-1:0] acc_q, acc_nxt, smp_scaled;
  logic signed [ACC_W:0]   diff;
  logic signed [EST_W-1:0] est;
  logic signed [SUB_W-1:0] sub;
  logic signed [SMP_W-1:0] sat_res;
  logic        [SMP_W-1:0] res_q;

  assign smp_scaled = {smp_i[SMP_W-1], smp_i, {SHIFT_K{1'b0}}};
  assign diff       = {smp_scaled[ACC_W-1], smp_scaled} - {acc_q[ACC_W-1], acc_q};
  // arithmetic shift by slicing: floor division by 2^K
  assign acc_nxt    = acc_q + {{(SHIFT_K-1){diff[ACC_W]}}, diff[ACC_W:SHIFT_K]};
  assign est        = acc_q[ACC_W-1:SHIFT_K];
  assign sub        = {{2{smp_i[SMP_W-1]}}, smp_i} - {est[EST_W-1], est};

  dcf_sat #(.IN_W(SUB_W), .OUT_W(SMP_W)) i_sat (
    .din_i  (sub),
    .dout_o (sat_res)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
      res_q <= '0;
    end else if (srst_i) begin
      acc_q <= '0;
      res_q <= '0;
    end else if (valid_i) begin
      res_q <= (mode_i == MODE_BYPASS) ? smp_i : sat_res;
      if (mode_i == MODE_TRACK) acc_q <= acc_nxt;
    end
  end

  assign res_o = res_q;
  assign acc_o = acc_q;
endmodule

// File: rtl/dc_block_filter.sv
module dc_block_filter
  import dcf_pkg::*;
#(
  parameter int SMP_W   = 24,
  parameter int SHIFT_K = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             srst_i,
  input  logic             valid_i,
  input  logic             enable_i,
  input  logic             freeze_i,
  input  logic [SMP_W-1:0] left_i,
  input  logic [SMP_W-1:0] right_i,
  output logic             valid_o,
  output logic [SMP_W-1:0] left_o,
  output logic [SMP_W-1:0] right_o
);
  localparam int NUM_CH = 2;
  localparam int ACC_W  = SMP_W + SHIFT_K + 1;

  logic                              primed_q, valid_q;
  dcf_mode_e                         mode;
  logic [NUM_CH-1:0][SMP_W-1:0]      smp_in, smp_out;
  logic [NUM_CH-1:0][ACC_W-1:0]      acc_w;

  // freeze only takes hold once a sample has seeded the estimate
  always_comb begin
    if (!enable_i)                 mode = MODE_BYPASS;
    else if (freeze_i && primed_q) mode = MODE_HOLD;
    else                           mode = MODE_TRACK;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      primed_q <= 1'b0;
      valid_q  <= 1'b0;
    end else if (srst_i) begin
      primed_q <= 1'b0;
      valid_q  <= 1'b0;
    end else begin
      valid_q <= valid_i;
      if (valid_i) primed_q <= 1'b1;
    end
  end

  assign smp_in[0] = left_i;
  assign smp_in[1] = right_i;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    dcf_channel #(.SMP_W(SMP_W), .SHIFT_K(SHIFT_K)) i_ch (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .srst_i  (srst_i),
      .valid_i (valid_i),
      .mode_i  (mode),
      .smp_i   (smp_in[c]),
      .res_o   (smp_out[c]),
      .acc_o   (acc_w[c])
    );
  end

  assign valid_o = valid_q;
  assign left_o  = smp_out[0];
  assign right_o = smp_out[1];
endmodule

// File: rtl/dcf_checker.sv
module dcf_checker #(
  parameter int SMP_W = 24,
  parameter int ACC_W = 37
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic                   srst_i,
  input logic                   valid_i,
  input logic                   enable_i,
  input logic                   freeze_i,
  input logic [SMP_W-1:0]       left_i,
  input logic                   valid_o,
  input logic [SMP_W-1:0]       left_o,
  input logic [SMP_W-1:0]       right_o,
  input logic                   primed_i,
  input logic [1:0][ACC_W-1:0]  acc_i
);
  a_r2_valid_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && !srst_i |=> valid_o);

  a_r2_idle_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i && !srst_i |=> !valid_o && $stable(left_o) && $stable(right_o));

  a_r6_freeze_holds_est: assert property (@(posedge clk_i) disable iff (!rst_ni)
    enable_i && freeze_i && primed_i && !srst_i |=> $stable(acc_i));

  a_r7_first_sample_primes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && !srst_i |=> primed_i);

  a_r9_bypass_passes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && !enable_i && !srst_i |=> left_o == $past(left_i) && $stable(acc_i));

  a_r10_sync_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    srst_i |=> acc_i == '0 && !valid_o && !primed_i && left_o == '0);
endmodule

bind dc_block_filter dcf_checker #(.SMP_W(SMP_W), .ACC_W(ACC_W)) i_dcf_checker (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .srst_i   (srst_i),
  .valid_i  (valid_i),
  .enable_i (enable_i),
  .freeze_i (freeze_i),
  .left_i   (left_i),
  .valid_o  (valid_o),
  .left_o   (left_o),
  .right_o  (right_o),
  .primed_i (primed_q),
  .acc_i    (acc_w)
);

// File: tb/test_dc_block_filter.sv
module test_dc_block_filter;
  localparam int W = 24;
  localparam int K = 12;
  localparam longint SMAX = 8388607;
  localparam longint SMIN = -8388608;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic srst = 1'b0, vld = 1'b0, en = 1'b1, frz = 1'b0;
  logic [W-1:0] l_in = '0, r_in = '0;
  logic vld_o;
  logic [W-1:0] l_out, r_out;

  int n_cmp = 0, n_bad = 0;
  longint acc [2];
  bit primed;
  logic exp_vld;
  logic [W-1:0] exp_l, exp_r;
  logic [15:0] lfsr = 16'hACE1;

  always #10 clk = ~clk;

  dc_block_filter #(.SMP_W(W), .SHIFT_K(K)) i_dc_block_filter (
    .clk_i(clk), .rst_ni(rst_n), .srst_i(srst), .valid_i(vld),
    .enable_i(en), .freeze_i(frz), .left_i(l_in), .right_i(r_in),
    .valid_o(vld_o), .left_o(l_out), .right_o(r_out)
  );

  function automatic longint sat(longint v);
    if (v > SMAX) return SMAX;
    if (v < SMIN) return SMIN;
    return v;
  endfunction

  function automatic longint chan(int c, longint x, bit upd, bit byp);
    longint y;
    y = byp ? x : sat(x - (acc[c] >>> K));
    if (upd) acc[c] = acc[c] + (((x <<< K) - acc[c]) >>> K);
    return y;
  endfunction

  task automatic compare(string req);
    n_cmp++;
    if (vld_o !== exp_vld || l_out !== exp_l || r_out !== exp_r) begin
      n_bad++;
      $display("FAIL %s: got vld=%0b l=%0d r=%0d, expected vld=%0b l=%0d r=%0d",
               req, vld_o, $signed(l_out), $signed(r_out),
               exp_vld, $signed(exp_l), $signed(exp_r));
    end
  endtask

  // one clock: drive at negedge, model, compare at the following negedge
  task automatic step(string req, bit v, longint l, longint r);
    bit upd, byp;
    vld  = v;
    l_in = l[W-1:0];
    r_in = r[W-1:0];
    if (srst) begin
      acc[0] = 0; acc[1] = 0; primed = 0;
      exp_vld = 0; exp_l = '0; exp_r = '0;
    end else begin
      exp_vld = v;
      if (v) begin
        byp = !en;
        upd = en && !(frz && primed);
        exp_l = chan(0, l, upd, byp)[W-1:0];
        exp_r = chan(1, r, upd, byp)[W-1:0];
        primed = 1;
      end
    end
    @(posedge clk);
    @(negedge clk);
    compare(req);
  endtask

  task automatic run_dc(string req, int n, longint dl, longint dr, bit gaps);
    for (int i = 0; i < n; i++) begin
      bit v;
      longint rip;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      v    = gaps ? lfsr[0] | lfsr[3] : 1'b1;
      rip  = longint'(lfsr[7:0]) - 128;
      step(req, v, dl + rip, dr - rip);
    end
  endtask

  initial begin
    #(20 * 190000);
    n_bad++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    acc[0] = 0; acc[1] = 0; primed = 0;
    exp_vld = 0; exp_l = '0; exp_r = '0;
    @(negedge clk); @(negedge clk);
    compare("R1 reset state");
    rst_n = 1'b1;
    @(negedge clk);
    compare("R1 after reset release");
    // R7: freeze asserted before any sample; first sample must still learn
    frz = 1'b1;
    step("R1 first sample passes unchanged", 1, 300000, -200000);
    step("R7 freeze ignored on first sample", 1, 300000, -200000);
    step("R7 held after first sample", 1, 300000, -200000);
    frz = 1'b0;
    // R3/R4: opposite-sign DC levels settle independently
    run_dc("R4 tracking opposite DC", 30000, 1500000, -2500000, 0);
    step("R3 residual after settling", 1, 1500000, -2500000);
    // R2: gapped strobe with ripple
    run_dc("R2 gapped strobe", 3000, 1500000, -2500000, 1);
    // R6: freeze, then step the DC
    frz = 1'b1;
    run_dc("R6 frozen estimate subtracted", 2000, 2000000, -1000000, 1);
    // R8: release and keep learning from the held value
    frz = 1'b0;
    step("R8 resume without jump", 1, 2000000, -1000000);
    run_dc("R8 resumed tracking", 2000, 2000000, -1000000, 0);
    // R9: bypass
    en = 1'b0;
    run_dc("R9 bypass passthrough", 500, 123456, -654321, 1);
    en = 1'b1;
    // R5: learn large offsets then drive full scale of opposite sign
    run_dc("R5 learn large offset", 30000, -4000000, 4000000, 0);
    step("R5 saturate high and low", 1, SMAX, SMIN);
    step("R5 saturate repeated", 1, SMAX, SMIN);
    step("R5 in range again", 1, -4000000, 4000000);
    // R10: synchronous clear mid-stream
    srst = 1'b1;
    step("R10 sync clear", 1, 777, -777);
    srst = 1'b0;
    step("R10 first sample after clear", 1, 5000, -5000);
    frz = 1'b1;
    step("R7 freeze ignored after clear", 1, 5000, -5000);
    step("R6 held after clear", 1, 5000, -5000);
    frz = 1'b0;
    step("R2 idle cycle", 0, 1, 1);
    step("R2 idle cycle again", 0, 2, 2);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule